// File: doc/BRIEF.md
# Five-stage pipelined integer core

This block is a 32-bit in-order core that overlaps the execution of up to five instructions. Each instruction walks through fetch, register read and decode, execute, memory access and write-back, one stage per clock, so a new instruction can start on every cycle. Instruction and data memories are separate and sit outside the block. Both answer in the same cycle as the address they are given. The block has no back-pressure: neither memory can stall the core, and the retirement port has no ready signal.

The core resolves its hazards in three ways. ALU results are bypassed into the execute stage. An instruction that consumes a load result in the very next slot waits behind one bubble. Branches are assumed not taken; a taken branch squashes the two younger instructions and fetch resumes at the target. Every register write happens in the last stage, so the register file needs only one write port. Each register write is reported on a retirement port, which is the way the surrounding system observes architectural state.

Top module: `pipe5_core`

## Requirements
- R1: Instruction fields are: opcode in bits [31:26], first source in [25:21], second source or immediate-form destination in [20:16], register-form destination in [15:11], function in [2:0], and a 16-bit immediate in [15:0]. The opcodes are 0 register form, 1 OR with the zero-extended immediate, 2 load word from first source plus the sign-extended immediate, 3 store word of the second source to the same kind of address, and 4 branch if the two sources are equal, with target = own address + 4 + (sign-extended immediate << 2). The function codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed set-less-than.
- R2: Straight-line code retires one instruction per cycle. The instruction at word k appears on the retirement port after rising edge 4+k, counting the first rising edge with reset released as edge 1. Fetch addresses are always word aligned.
- R3: Every register write takes place in the write-back stage. A write is visible to a reader in the decode stage during the same cycle, so an instruction three slots after the writer reads the new value.
- R4: A result needed by the next or the second-next instruction is forwarded to the execute operands. When both in-flight producers target the same register, the younger one wins.
- R5: Register 0 always reads as zero. Writes to it are dropped and never forwarded, and the retirement port never reports register 0.
- R6: When an instruction uses a load's destination in the slot right after the load, exactly one bubble is inserted, so the two retire 2 cycles apart. A consumer two slots after a load does not stall.
- R7: Branches resolve in execute with not-taken prediction. A taken branch squashes the two younger instructions, so the last write before the branch and the first write at the target retire 5 cycles apart when the branch is preceded by a non-writing instruction. A not-taken branch costs nothing.
- R8: A squashed or bubbled instruction performs no register write and no memory store.
- R9: While reset is low the fetch address equals the reset address (0), and no store and no retirement is signalled.
- R10: Store data is forwarded like an ALU operand, including after a one-bubble load-use stall on the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, writes at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| retire_valid | output | 1 | A register write is happening this cycle |
| retire_reg | output | 5 | Destination register of that write |
| retire_data | output | 32 | Value written |

## Verification
The assertions assume that both memories return their word combinationally in the cycle the address is presented, and that reset is held low across at least one rising edge before the first instruction is fetched. The stimulus keeps to these conditions. Programs stay inside a small word-aligned address window. Each program ends in a branch to itself, so the instruction stream never runs past the loaded words. Reset is released only at a falling edge after several cycles low. With the stream kept this way, the single-bubble and squash properties describe the pipeline's control rather than any memory behaviour.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5
  } alu_e;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_EM   = 2'd1,
    FWD_MW   = 2'd2
  } fwd_e;

  localparam logic [5:0] OPC_REG = 6'd0;
  localparam logic [5:0] OPC_ORI = 6'd1;
  localparam logic [5:0] OPC_LD  = 6'd2;
  localparam logic [5:0] OPC_ST  = 6'd3;
  localparam logic [5:0] OPC_BEQ = 6'd4;

  typedef struct packed {
    logic       wr;
    logic       ld;
    logic       st;
    logic       br;
    logic       imm_sel;
    logic       zext;
    logic       use_rt;
    alu_e       alu;
    logic [4:0] dst;
  } ctrl_t;

  function automatic ctrl_t decode(input logic [5:0] op, input logic [2:0] fn,
                                   input logic [4:0] rt, input logic [4:0] rd);
    ctrl_t c;
    c = '0;
    c.alu = ALU_ADD;
    case (op)
      OPC_REG: begin
        c.wr = 1'b1; c.use_rt = 1'b1; c.dst = rd;
        c.alu = (fn <= 3'd5) ? alu_e'(fn) : ALU_ADD;
      end
      OPC_ORI: begin
        c.wr = 1'b1; c.imm_sel = 1'b1; c.zext = 1'b1; c.dst = rt; c.alu = ALU_OR;
      end
      OPC_LD: begin
        c.wr = 1'b1; c.ld = 1'b1; c.imm_sel = 1'b1; c.dst = rt;
      end
      OPC_ST: begin
        c.st = 1'b1; c.imm_sel = 1'b1; c.use_rt = 1'b1;
      end
      OPC_BEQ: begin
        c.br = 1'b1; c.use_rt = 1'b1;
      end
      default: c = c;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W    = 32,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ra_a,
  input  logic [RA_W-1:0] ra_b,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [W-1:0]    wd
);
  localparam int NREG = 1 << RA_W;

  logic [W-1:0] regs [NREG];

  // write lands early in the cycle: a same-cycle reader sees it (R3)
  always_comb begin
    rd_a = (we && wa == ra_a && wa != '0) ? wd : regs[ra_a];
    rd_b = (we && wa == ra_b && wa != '0) ? wd : regs[ra_b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
  import pipe5_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            fd_valid,
  input  logic [RA_W-1:0] fd_rs,
  input  logic [RA_W-1:0] fd_rt,
  input  logic            fd_use_rt,
  input  logic            de_valid,
  input  logic            de_ld,
  input  logic [RA_W-1:0] de_dst,
  input  logic [RA_W-1:0] de_rs,
  input  logic [RA_W-1:0] de_rt,
  input  logic            em_valid,
  input  logic            em_wr,
  input  logic            em_ld,
  input  logic [RA_W-1:0] em_dst,
  input  logic            mw_valid,
  input  logic            mw_wr,
  input  logic [RA_W-1:0] mw_dst,
  output logic            stall,
  output fwd_e            fwd_a,
  output fwd_e            fwd_b
);
  logic [RA_W-1:0] src [2];
  fwd_e            sel [2];

  assign src[0] = de_rs;
  assign src[1] = de_rt;

  // one selector per execute operand; youngest producer first, r0 excluded
  for (genvar g = 0; g < 2; g++) begin : g_fwd
    always_comb begin
      if (em_valid && em_wr && !em_ld && em_dst != '0 && em_dst == src[g])
        sel[g] = FWD_EM;
      else if (mw_valid && mw_wr && mw_dst != '0 && mw_dst == src[g])
        sel[g] = FWD_MW;
      else
        sel[g] = FWD_NONE;
    end
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  assign stall = de_valid && de_ld && de_dst != '0 && fd_valid &&
                 ((fd_rs == de_dst) || (fd_use_rt && fd_rt == de_dst));
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            retire_valid,
  output logic [4:0]      retire_reg,
  output logic [XLEN-1:0] retire_data
);
  localparam int RA_W = 5;
  localparam int IMM_W = 16;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // fetch
  logic [XLEN-1:0] pc_q;
  logic            stall, br_take;
  logic [XLEN-1:0] br_target;

  // fetch/decode register
  logic            fd_valid;
  logic [31:0]     fd_inst;
  logic [XLEN-1:0] fd_pc;

  // decode
  ctrl_t           id_ctl;
  logic [RA_W-1:0] id_rs, id_rt;
  logic [XLEN-1:0] id_a, id_b, id_imm;
  logic [7:0]      unused_bits;

  // decode/execute register
  logic            de_valid, de_wr, de_ld, de_st, de_br, de_imm_sel;
  alu_e            de_alu;
  logic [RA_W-1:0] de_dst, de_rs, de_rt;
  logic [XLEN-1:0] de_a, de_b, de_imm, de_pc;

  // execute
  fwd_e            fwd_a, fwd_b;
  logic [XLEN-1:0] ex_a, ex_b, ex_y;

  // execute/memory register
  logic            em_valid, em_wr, em_ld, em_st;
  logic [RA_W-1:0] em_dst;
  logic [XLEN-1:0] em_res, em_sd;

  // memory/write-back register
  logic            mw_valid, mw_wr;
  logic [RA_W-1:0] mw_dst;
  logic [XLEN-1:0] mw_data;
  logic            wb_we;

  function automatic logic [XLEN-1:0] pick(input fwd_e s, input logic [XLEN-1:0] rf,
                                           input logic [XLEN-1:0] em, input logic [XLEN-1:0] mw);
    case (s)
      FWD_EM:  return em;
      FWD_MW:  return mw;
      default: return rf;
    endcase
  endfunction

  // ---------------- fetch ----------------
  assign imem_addr = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= XLEN'(RESET_PC);
      fd_valid <= 1'b0;
      fd_inst  <= '0;
      fd_pc    <= '0;
    end else if (br_take) begin
      pc_q     <= br_target;
      fd_valid <= 1'b0;
    end else if (!stall) begin
      pc_q     <= pc_q + STEP;
      fd_valid <= 1'b1;
      fd_inst  <= imem_rdata;
      fd_pc    <= pc_q;
    end
  end

  // ---------------- decode ----------------
  assign id_rs       = fd_inst[25:21];
  assign id_rt       = fd_inst[20:16];
  assign unused_bits = fd_inst[10:3];
  assign id_ctl      = decode(fd_inst[31:26], fd_inst[2:0], id_rt, fd_inst[15:11]);
  assign id_imm      = id_ctl.zext ? {{(XLEN-IMM_W){1'b0}}, fd_inst[15:0]}
                                   : {{(XLEN-IMM_W){fd_inst[15]}}, fd_inst[15:0]};

  pipe5_regfile #(.W(XLEN), .RA_W(RA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(id_rs), .ra_b(id_rt), .rd_a(id_a), .rd_b(id_b),
    .we(wb_we), .wa(mw_dst), .wd(mw_data)
  );

  pipe5_hazard #(.RA_W(RA_W)) u_hz (
    .fd_valid(fd_valid), .fd_rs(id_rs), .fd_rt(id_rt), .fd_use_rt(id_ctl.use_rt),
    .de_valid(de_valid), .de_ld(de_ld), .de_dst(de_dst), .de_rs(de_rs), .de_rt(de_rt),
    .em_valid(em_valid), .em_wr(em_wr), .em_ld(em_ld), .em_dst(em_dst),
    .mw_valid(mw_valid), .mw_wr(mw_wr), .mw_dst(mw_dst),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_valid <= 1'b0;
      de_wr <= 1'b0; de_ld <= 1'b0; de_st <= 1'b0; de_br <= 1'b0; de_imm_sel <= 1'b0;
      de_alu <= ALU_ADD;
      de_dst <= '0; de_rs <= '0; de_rt <= '0;
      de_a <= '0; de_b <= '0; de_imm <= '0; de_pc <= '0;
    end else begin
      // bubble on load-use, squash on taken branch (R6, R7)
      de_valid   <= fd_valid && !stall && !br_take;
      de_wr      <= id_ctl.wr;
      de_ld      <= id_ctl.ld;
      de_st      <= id_ctl.st;
      de_br      <= id_ctl.br;
      de_imm_sel <= id_ctl.imm_sel;
      de_alu     <= id_ctl.alu;
      de_dst     <= id_ctl.dst;
      de_rs      <= id_rs;
      de_rt      <= id_rt;
      de_a       <= id_a;
      de_b       <= id_b;
      de_imm     <= id_imm;
      de_pc      <= fd_pc;
    end
  end

  // ---------------- execute ----------------
  assign ex_a = pick(fwd_a, de_a, em_res, mw_data);
  assign ex_b = pick(fwd_b, de_b, em_res, mw_data);

  pipe5_alu #(.W(XLEN)) u_alu (
    .op(de_alu), .a(ex_a), .b(de_imm_sel ? de_imm : ex_b), .y(ex_y)
  );

  assign br_take   = de_valid && de_br && (ex_a == ex_b);
  assign br_target = de_pc + STEP + {de_imm[XLEN-3:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_valid <= 1'b0; em_wr <= 1'b0; em_ld <= 1'b0; em_st <= 1'b0;
      em_dst <= '0; em_res <= '0; em_sd <= '0;
    end else begin
      em_valid <= de_valid;
      em_wr    <= de_wr;
      em_ld    <= de_ld;
      em_st    <= de_st;
      em_dst   <= de_dst;
      em_res   <= ex_y;
      em_sd    <= ex_b;
    end
  end

  // ---------------- memory ----------------
  assign dmem_addr  = em_res;
  assign dmem_wdata = em_sd;
  assign dmem_we    = em_valid && em_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_valid <= 1'b0; mw_wr <= 1'b0; mw_dst <= '0; mw_data <= '0;
    end else begin
      mw_valid <= em_valid;
      mw_wr    <= em_wr;
      mw_dst   <= em_dst;
      mw_data  <= em_ld ? dmem_rdata : em_res;
    end
  end

  // ---------------- write-back ----------------
  assign wb_we        = mw_valid && mw_wr && mw_dst != '0;
  assign retire_valid = wb_we;
  assign retire_reg   = mw_dst;
  assign retire_data  = mw_data;
endmodule

// File: rtl/pipe5_chk.sv
module pipe5_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          br_take,
  input logic          fd_valid,
  input logic          de_valid,
  input logic          dmem_we,
  input logic          retire_valid,
  input logic [4:0]    retire_reg,
  input logic [AW-1:0] imem_addr
);
  // R6: a load-use stall lasts one cycle and leaves a bubble behind
  p_single_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  p_bubble_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !de_valid);

  // R7: taken branch empties both younger slots
  p_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (!fd_valid && !de_valid));

  // R8: the squashed instruction reaching memory never stores
  p_squashed_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> ##1 !dmem_we);

  // R5: register 0 is never reported as written
  p_no_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> retire_reg != 5'd0);

  // R2: fetch stays word aligned
  p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);
endmodule

bind pipe5_core pipe5_chk #(.AW(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take),
  .fd_valid(fd_valid), .de_valid(de_valid), .dmem_we(dmem_we),
  .retire_valid(retire_valid), .retire_reg(retire_reg), .imem_addr(imem_addr)
);

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 64;
  localparam int RUN_CYC    = 120;
  localparam int MAXREC     = 64;
  localparam int WDOG_CYC   = 100000;

  function automatic logic [31:0] e_rr(int f, int d, int s, int t);
    return {6'd0, s[4:0], t[4:0], d[4:0], 8'd0, f[2:0]};
  endfunction
  function automatic logic [31:0] e_i(int op, int t, int s, int imm);
    return {op[5:0], s[4:0], t[4:0], imm[15:0]};
  endfunction

  localparam logic [31:0] HALT = e_i(4, 0, 0, -1);

  // program table: opcodes 0 reg,1 ori,2 load,3 store,4 beq; funct 0 add..5 slt
  localparam int NPROG = 3;
  localparam int ROM_N = 39;
  localparam int P_START [NPROG] = '{0, 17, 28};
  localparam int P_LEN   [NPROG] = '{17, 11, 11};
  localparam logic [31:0] ROM [ROM_N] = '{
    // program 0: forwarding, write-first file, register 0, ALU ops
    e_i(1,1,0,5), e_i(1,2,0,3), e_rr(0,3,1,2), e_rr(1,4,3,1), e_rr(2,5,3,4),
    e_rr(3,6,4,3), e_rr(4,7,6,1), e_rr(5,8,4,3), e_rr(0,0,1,1), e_rr(0,9,0,2),
    e_i(1,10,0,65535), e_rr(1,11,0,1), e_rr(5,12,11,1),
    e_i(1,13,0,1), e_i(1,13,0,2), e_rr(0,14,13,13), HALT,
    // program 1: loads, stores, load-use
    e_i(1,1,0,64), e_i(1,2,0,291), e_i(3,2,1,4), e_i(2,3,1,4), e_rr(0,4,3,3),
    e_i(2,5,1,4), e_i(1,6,0,1), e_rr(0,7,5,6), e_i(2,8,1,-4), e_i(3,8,0,0), HALT,
    // program 2: loop with taken and not-taken branches, dead code after halt
    e_i(1,1,0,4), e_i(1,3,0,1), e_rr(1,1,1,3), e_rr(0,2,2,1), e_i(4,0,1,1),
    e_i(4,0,0,-4), e_i(4,2,1,2), e_i(1,4,0,7), HALT, e_i(1,5,0,9), e_i(3,3,0,0)
  };
  localparam string P_TAG [NPROG] = '{"R1/R3/R4/R5", "R6/R10", "R7/R8"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, retire_data;
  logic        dmem_we, retire_valid;
  logic [4:0]  retire_reg;

  logic [31:0] imem [MEMW];
  logic [31:0] dmem [MEMW];

  int checks = 0, errors = 0, cyc = 0, total = 0;

  // observed and expected traces
  int          n_got, n_gst, n_exp, n_exs;
  logic [4:0]  got_reg [MAXREC];
  logic [31:0] got_dat [MAXREC];
  int          got_cyc [MAXREC];
  logic [31:0] got_sa [MAXREC], got_sd [MAXREC];
  logic [4:0]  exp_reg [MAXREC];
  logic [31:0] exp_dat [MAXREC];
  logic [31:0] exp_sa [MAXREC], exp_sd [MAXREC];

  pipe5_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
    .retire_valid(retire_valid), .retire_reg(retire_reg), .retire_data(retire_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_got = 0; n_gst = 0;
    end else begin
      if (retire_valid && n_got < MAXREC) begin
        got_reg[n_got] = retire_reg; got_dat[n_got] = retire_data; got_cyc[n_got] = cyc;
        n_got++;
      end
      if (dmem_we && n_gst < MAXREC) begin
        got_sa[n_gst] = dmem_addr; got_sd[n_gst] = dmem_wdata; n_gst++;
      end
    end
  end

  function automatic logic [31:0] dinit(int i);
    return 32'h1000_0000 + i * 32'h0001_0203;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic load_prog(input int p);
    for (int i = 0; i < MEMW; i++) begin
      imem[i] = (i < P_LEN[p]) ? ROM[P_START[p] + i] : 32'h0;
      dmem[i] = dinit(i);
    end
  endtask

  // instruction-level model of the requirements
  task automatic ref_run;
    logic [31:0] rr [32];
    logic [31:0] rm [MEMW];
    logic [31:0] in, a, b, v, sx, zx, ad;
    logic [4:0]  dst;
    int          pcw;
    bit          wr;
    for (int i = 0; i < 32; i++) rr[i] = '0;
    for (int i = 0; i < MEMW; i++) rm[i] = dinit(i);
    n_exp = 0; n_exs = 0; pcw = 0;
    for (int step = 0; step < 400; step++) begin
      in = imem[pcw[5:0]];
      if (in == HALT) break;
      a  = rr[in[25:21]]; b = rr[in[20:16]];
      sx = {{16{in[15]}}, in[15:0]}; zx = {16'h0, in[15:0]};
      wr = 1'b0; dst = in[20:16]; v = '0; ad = a + sx;
      pcw = pcw + 1;
      case (in[31:26])
        6'd0: begin
          wr = 1'b1; dst = in[15:11];
          case (in[2:0])
            3'd1: v = a - b;
            3'd2: v = a & b;
            3'd3: v = a | b;
            3'd4: v = a ^ b;
            3'd5: v = {31'h0, ($signed(a) < $signed(b))};
            default: v = a + b;
          endcase
        end
        6'd1: begin wr = 1'b1; v = a | zx; end
        6'd2: begin wr = 1'b1; v = rm[ad[7:2]]; end
        6'd3: begin
          rm[ad[7:2]] = b;
          exp_sa[n_exs] = ad; exp_sd[n_exs] = b; n_exs++;
        end
        6'd4: if (a == b) pcw = pcw + int'($signed(in[15:0]));
        default: ;
      endcase
      if (wr && dst != 5'd0) begin
        rr[dst] = v;
        exp_reg[n_exp] = dst; exp_dat[n_exp] = v; n_exp++;
      end
    end
  endtask

  task automatic run_prog(input int p);
    rst_n = 1'b0;
    load_prog(p);
    ref_run();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (RUN_CYC) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      total++;
      if (total > WDOG_CYC) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", total, WDOG_CYC);
        finish_run();
      end
    end
  end

  initial begin
    // reset state (R9)
    load_prog(0);
    repeat (3) @(negedge clk);
    check(imem_addr == 32'h0, "R9", "fetch address in reset", imem_addr, 32'h0);
    check(!retire_valid && !dmem_we, "R9", "quiet in reset",
          {30'h0, retire_valid, dmem_we}, 32'h0);

    // table of programs against the model
    for (int p = 0; p < NPROG; p++) begin
      run_prog(p);
      check(n_got == n_exp, P_TAG[p], "retire count", n_got, n_exp);
      for (int k = 0; k < n_exp && k < n_got; k++)
        check(got_reg[k] == exp_reg[k] && got_dat[k] == exp_dat[k], P_TAG[p],
              "retire reg/data", {got_reg[k], got_dat[k][26:0]}, {exp_reg[k], exp_dat[k][26:0]});
      check(n_gst == n_exs, P_TAG[p], "store count", n_gst, n_exs);
      for (int k = 0; k < n_exs && k < n_gst; k++)
        check(got_sa[k] == exp_sa[k] && got_sd[k] == exp_sd[k], P_TAG[p],
              "store addr/data", got_sd[k] ^ got_sa[k], exp_sd[k] ^ exp_sa[k]);
    end

    // R8: the dead store after the halt in program 2 never reaches memory
    check(n_gst == 0, "R8", "stores from squashed code", n_gst, 0);

    // R2: first retire after edge 4, then one per cycle
    run_prog(0);
    check(got_cyc[0] == 4, "R2", "first retire edge", got_cyc[0], 4);
    check(got_cyc[1] - got_cyc[0] == 1, "R2", "back-to-back retire", got_cyc[1] - got_cyc[0], 1);
    check(got_dat[7] == 32'h1, "R1", "signed less-than result", got_dat[7], 32'h1);

    // R6: one bubble for an adjacent consumer, none two slots away
    run_prog(1);
    check(got_cyc[3] - got_cyc[2] == 2, "R6", "load-use gap", got_cyc[3] - got_cyc[2], 2);
    check(got_cyc[6] - got_cyc[5] == 1, "R6", "no stall two slots after load",
          got_cyc[6] - got_cyc[5], 1);

    // R7: taken branch costs two cycles
    run_prog(2);
    check(got_cyc[4] - got_cyc[3] == 5, "R7", "taken-branch gap", got_cyc[4] - got_cyc[3], 5);

    // R9: reset mid-run clears activity and restarts at address 0
    load_prog(2);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(imem_addr == 32'h0 && !retire_valid && !dmem_we, "R9", "reset during run",
          imem_addr | {30'h0, retire_valid, dmem_we}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(n_got > 0 && got_cyc[0] == 4 && got_reg[0] == 5'd1, "R9", "restart retire edge",
          got_cyc[0], 4);

    finish_run();
  end
endmodule